// File: doc/BRIEF.md
# Squared-Norm Cell Network

This block computes `vx*vx + vy*vy` for a stream of coordinate pairs. It is not built as one multiply-add datapath. It is a small network of independent processing cells linked by point-to-point FIFO channels.

Each coordinate stream enters its own channel. It then reaches a duplicator cell, which writes every word twice, once to each of two channels. Both of those channels feed the same multiplier cell, so that cell squares the coordinate. The two squares travel through their own channels to an adder cell. The adder's sum goes through a final channel to the output port.

Every cell waits (blocks) on the channel it is reading. A cell can always write while the channel it writes to has room, and it stalls when that channel is full. A full input channel lowers the ready of its port. The two coordinate streams are independent valid/ready inputs, and they may arrive at different rates. Results leave in pair order.

Top module: `sqnorm_net`

## Requirements
- R1: Each result equals the low 32 bits of vx*vx + vy*vy, with products and the sum wrapping modulo 2^32. Signed inputs give the same low bits as unsigned ones.
- R2: Exactly one result is produced for each (vx, vy) pair. Results come out in the order the pairs were accepted. The n-th vx is paired with the n-th vy.
- R3: While `norm_valid` is high and `norm_ready` is low, `norm_data` holds its value. No result is lost or duplicated under output back-pressure.
- R4: A cell blocks on an empty channel. With vx words present but no vy word, no result appears. Once the matching vy words arrive, the results are correct.
- R5: Channels have a finite depth (default 32 words). When the path is blocked downstream, an input's ready eventually goes low. Every word accepted before that point still produces its correct result.
- R6: A synchronous active-high reset empties every channel and returns every cell to its first receive step. After reset `norm_valid` is 0 and both input readies are 1. Words accepted before the reset never produce a result.
- R7: The data width and the channel depth are parameters. The default is 32 bits and 32 words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| vx_valid | input | 1 | vx word offered |
| vx_ready | output | 1 | vx channel has room |
| vx_data | input | W | vx coordinate |
| vy_valid | input | 1 | vy word offered |
| vy_ready | output | 1 | vy channel has room |
| vy_data | input | W | vy coordinate |
| norm_valid | output | 1 | A result is available |
| norm_ready | input | 1 | Consumer takes the result |
| norm_data | output | W | vx*vx + vy*vy modulo 2^W |

## Verification
The bench feeds one coordinate stream while starving the other. A design that forgot to block would emit results built from stale or zero operands. It also stalls the output until the channels fill. A design that dropped or overwrote words would then show missing or reordered results, or data that changes while valid is held.

Wrap-around operands (65536 squared, 65535 squared twice) expose a datapath that keeps the wrong product bits. A reset in the middle of a pair exposes leftover half-pairs that would pair with the next vy.

// File: rtl/sqnorm_pkg.sv
package sqnorm_pkg;
    localparam int unsigned WORD_W_DEF = 32;
    localparam int unsigned CHAN_DEPTH_DEF = 32;

    typedef enum logic {
        OP_MUL,
        OP_ADD
    } cell_op_e;

    typedef enum logic [1:0] {
        BIN_TAKE_A,
        BIN_TAKE_B,
        BIN_EMIT
    } bin_state_e;

    typedef enum logic [1:0] {
        DUP_TAKE,
        DUP_EMIT_1,
        DUP_EMIT_2
    } dup_state_e;
endpackage

// File: rtl/sqnorm_chan.sv
module sqnorm_chan #(
    parameter int unsigned W     = 32,
    parameter int unsigned DEPTH = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    logic [W-1:0]  store [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] fill;
    logic          push, pop;

    assign in_ready  = (fill != FULL);
    assign out_valid = (fill != '0);
    assign out_data  = store[rd_ptr];
    assign push      = in_valid && in_ready;
    assign pop       = out_valid && out_ready;

    always_ff @(posedge clk) begin
        if (push) store[wr_ptr] <= in_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            case ({push, pop})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

    // R3: a word offered but not taken stays put
    a_r3_chan_hold: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
    // R6: reset leaves the channel empty and open
    a_r6_chan_clear: assert property (@(posedge clk)
        rst |=> (!out_valid && in_ready));
    // R5: a channel that refuses input must be holding words
    a_r5_full_nonempty: assert property (@(posedge clk) disable iff (rst)
        !in_ready |-> out_valid);
endmodule

// File: rtl/sqnorm_dup_cell.sv
module sqnorm_dup_cell
    import sqnorm_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         o1_valid,
    input  logic         o1_ready,
    output logic [W-1:0] o1_data,
    output logic         o2_valid,
    input  logic         o2_ready,
    output logic [W-1:0] o2_data
);
    dup_state_e   state;
    logic [W-1:0] held;

    assign in_ready = (state == DUP_TAKE);
    assign o1_valid = (state == DUP_EMIT_1);
    assign o2_valid = (state == DUP_EMIT_2);
    assign o1_data  = held;
    assign o2_data  = held;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= DUP_TAKE;
            held  <= '0;
        end else begin
            unique case (state)
                DUP_TAKE: if (in_valid) begin
                    held  <= in_data;
                    state <= DUP_EMIT_1;
                end
                DUP_EMIT_1: if (o1_ready) state <= DUP_EMIT_2;
                DUP_EMIT_2: if (o2_ready) state <= DUP_TAKE;
                default:    state <= DUP_TAKE;
            endcase
        end
    end

    // R2: the second copy follows the first and carries the same word
    a_r2_dup_second: assert property (@(posedge clk) disable iff (rst)
        (o1_valid && o1_ready) |=> (o2_valid && o2_data == $past(o1_data)));
    // R6: reset returns the cell to its receive step
    a_r6_dup_reset: assert property (@(posedge clk)
        rst |=> (in_ready && !o1_valid && !o2_valid));
endmodule

// File: rtl/sqnorm_bin_cell.sv
module sqnorm_bin_cell
    import sqnorm_pkg::*;
#(
    parameter int unsigned W  = 32,
    parameter cell_op_e    OP = OP_MUL
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         a_valid,
    output logic         a_ready,
    input  logic [W-1:0] a_data,
    input  logic         b_valid,
    output logic         b_ready,
    input  logic [W-1:0] b_data,
    output logic         r_valid,
    input  logic         r_ready,
    output logic [W-1:0] r_data
);
    bin_state_e   state;
    logic [W-1:0] opa, result_d, result_q;

    generate
        if (OP == OP_MUL) begin : g_mul
            assign result_d = opa * b_data;
        end else begin : g_add
            assign result_d = opa + b_data;
        end
    endgenerate

    assign a_ready = (state == BIN_TAKE_A);
    assign b_ready = (state == BIN_TAKE_B);
    assign r_valid = (state == BIN_EMIT);
    assign r_data  = result_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= BIN_TAKE_A;
            opa      <= '0;
            result_q <= '0;
        end else begin
            unique case (state)
                BIN_TAKE_A: if (a_valid) begin
                    opa   <= a_data;
                    state <= BIN_TAKE_B;
                end
                BIN_TAKE_B: if (b_valid) begin
                    result_q <= result_d;
                    state    <= BIN_EMIT;
                end
                BIN_EMIT: if (r_ready) state <= BIN_TAKE_A;
                default:  state <= BIN_TAKE_A;
            endcase
        end
    end

    // R4: a result only appears right after the second operand was taken
    a_r4_order: assert property (@(posedge clk) disable iff (rst)
        $rose(r_valid) |-> $past(b_valid && b_ready));
    // R3: a held result does not change
    a_r3_cell_hold: assert property (@(posedge clk) disable iff (rst)
        (r_valid && !r_ready) |=> (r_valid && $stable(r_data)));
endmodule

// File: rtl/sqnorm_net.sv
module sqnorm_net
    import sqnorm_pkg::*;
#(
    parameter int unsigned W     = WORD_W_DEF,
    parameter int unsigned DEPTH = CHAN_DEPTH_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         vx_valid,
    output logic         vx_ready,
    input  logic [W-1:0] vx_data,
    input  logic         vy_valid,
    output logic         vy_ready,
    input  logic [W-1:0] vy_data,
    output logic         norm_valid,
    input  logic         norm_ready,
    output logic [W-1:0] norm_data
);
    localparam int unsigned NLANE = 2;

    logic [NLANE-1:0]        src_v, src_r;
    logic [NLANE-1:0][W-1:0] src_d;
    logic [NLANE-1:0]        sq_v, sq_r;
    logic [NLANE-1:0][W-1:0] sq_d;
    logic                    sum_v, sum_r;
    logic [W-1:0]            sum_d;

    assign src_v    = {vy_valid, vx_valid};
    assign src_d    = {vy_data, vx_data};
    assign vx_ready = src_r[0];
    assign vy_ready = src_r[1];

    for (genvar l = 0; l < NLANE; l++) begin : g_lane
        logic         ci_v, ci_r, d1_v, d1_r, d2_v, d2_r;
        logic         m1_v, m1_r, m2_v, m2_r, pr_v, pr_r;
        logic [W-1:0] ci_d, d1_d, d2_d, m1_d, m2_d, pr_d;

        sqnorm_chan #(.W(W), .DEPTH(DEPTH)) u_in_chan (
            .clk, .rst,
            .in_valid(src_v[l]), .in_ready(src_r[l]), .in_data(src_d[l]),
            .out_valid(ci_v), .out_ready(ci_r), .out_data(ci_d));

        sqnorm_dup_cell #(.W(W)) u_dup (
            .clk, .rst,
            .in_valid(ci_v), .in_ready(ci_r), .in_data(ci_d),
            .o1_valid(d1_v), .o1_ready(d1_r), .o1_data(d1_d),
            .o2_valid(d2_v), .o2_ready(d2_r), .o2_data(d2_d));

        sqnorm_chan #(.W(W), .DEPTH(DEPTH)) u_v_chan (
            .clk, .rst,
            .in_valid(d1_v), .in_ready(d1_r), .in_data(d1_d),
            .out_valid(m1_v), .out_ready(m1_r), .out_data(m1_d));

        sqnorm_chan #(.W(W), .DEPTH(DEPTH)) u_w_chan (
            .clk, .rst,
            .in_valid(d2_v), .in_ready(d2_r), .in_data(d2_d),
            .out_valid(m2_v), .out_ready(m2_r), .out_data(m2_d));

        sqnorm_bin_cell #(.W(W), .OP(OP_MUL)) u_mul (
            .clk, .rst,
            .a_valid(m1_v), .a_ready(m1_r), .a_data(m1_d),
            .b_valid(m2_v), .b_ready(m2_r), .b_data(m2_d),
            .r_valid(pr_v), .r_ready(pr_r), .r_data(pr_d));

        sqnorm_chan #(.W(W), .DEPTH(DEPTH)) u_prod_chan (
            .clk, .rst,
            .in_valid(pr_v), .in_ready(pr_r), .in_data(pr_d),
            .out_valid(sq_v[l]), .out_ready(sq_r[l]), .out_data(sq_d[l]));
    end

    sqnorm_bin_cell #(.W(W), .OP(OP_ADD)) u_add (
        .clk, .rst,
        .a_valid(sq_v[0]), .a_ready(sq_r[0]), .a_data(sq_d[0]),
        .b_valid(sq_v[1]), .b_ready(sq_r[1]), .b_data(sq_d[1]),
        .r_valid(sum_v), .r_ready(sum_r), .r_data(sum_d));

    sqnorm_chan #(.W(W), .DEPTH(DEPTH)) u_out_chan (
        .clk, .rst,
        .in_valid(sum_v), .in_ready(sum_r), .in_data(sum_d),
        .out_valid(norm_valid), .out_ready(norm_ready), .out_data(norm_data));

    // R3: the output port holds its word under back-pressure
    a_r3_port_hold: assert property (@(posedge clk) disable iff (rst)
        (norm_valid && !norm_ready) |=> (norm_valid && $stable(norm_data)));
    // R6: after reset nothing is offered and both inputs are open
    a_r6_port_reset: assert property (@(posedge clk)
        rst |=> (!norm_valid && vx_ready && vy_ready));
endmodule

// File: tb/sqnorm_net_bench.sv
module sqnorm_net_bench;
    localparam int W = 32;
    localparam int NT = 8;
    localparam logic [31:0] TX [NT] = '{32'd3, 32'd0, 32'hFFFFFFFF, 32'd7,
        32'd65536, 32'd46341, 32'hFFFFFFFB, 32'd65535};
    localparam logic [31:0] TY [NT] = '{32'd4, 32'd0, 32'hFFFFFFFF, 32'hFFFFFFFE,
        32'd0, 32'd0, 32'd12, 32'd65535};
    localparam logic [31:0] TE [NT] = '{32'd25, 32'd0, 32'd2, 32'd53,
        32'd0, 32'h80001219, 32'd169, 32'hFFFC0002};

    logic clk = 0, rst = 1;
    logic vx_valid = 0, vy_valid = 0, norm_ready = 1;
    logic [W-1:0] vx_data = '0, vy_data = '0;
    logic vx_ready, vy_ready, norm_valid;
    logic [W-1:0] norm_data;

    int total_n = 0, pass_n = 0;
    logic [W-1:0] got [1024];
    int got_n = 0;
    logic [W-1:0] xs [512];
    logic [W-1:0] ys [512];

    always #5 clk = ~clk;

    sqnorm_net #(.W(W), .DEPTH(32)) u_sqnorm_net (
        .clk, .rst, .vx_valid, .vx_ready, .vx_data,
        .vy_valid, .vy_ready, .vy_data,
        .norm_valid, .norm_ready, .norm_data);

    always @(negedge clk) begin
        if (!rst && norm_valid && norm_ready && got_n < 1024) begin
            got[got_n] = norm_data;
            got_n++;
        end
    end

    function automatic logic [31:0] sq2(logic [31:0] a, logic [31:0] b);
        logic [31:0] pa, pb;
        pa = a * b; pb = 0;
        return pa;
    endfunction

    function automatic logic [31:0] expect_norm(logic [31:0] a, logic [31:0] b);
        return sq2(a, a) + sq2(b, b);
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        total_n++;
        if (ok) pass_n++;
        else $display("FAIL %s actual=%h expected=%h", req, act, exp);
    endtask

    task automatic push_x(input logic [W-1:0] v);
        @(posedge clk); #2;
        vx_valid = 1; vx_data = v;
        forever begin @(negedge clk); if (vx_ready) break; end
        @(posedge clk); #2;
        vx_valid = 0;
    endtask

    task automatic push_y(input logic [W-1:0] v);
        @(posedge clk); #2;
        vy_valid = 1; vy_data = v;
        forever begin @(negedge clk); if (vy_ready) break; end
        @(posedge clk); #2;
        vy_valid = 0;
    endtask

    task automatic push_pairs(input int n);
        fork
            for (int i = 0; i < n; i++) push_x(xs[i]);
            for (int i = 0; i < n; i++) push_y(ys[i]);
        join
    endtask

    task automatic wait_results(input int target);
        for (int c = 0; c < 4000 && got_n < target; c++) @(posedge clk);
        repeat (20) @(posedge clk);
    endtask

    task automatic do_reset();
        @(posedge clk); #2; rst = 1;
        repeat (2) @(posedge clk);
        #2; rst = 0;
    endtask

    task automatic run_all();
        int base, acc;
        bit stalled, ok;
        logic [31:0] held;

        repeat (3) @(posedge clk); #2; rst = 0;
        @(negedge clk);
        // R6 reset state
        check(!norm_valid, "R6 valid after reset", 32'(norm_valid), 0);
        check(vx_ready, "R6 vx_ready after reset", 32'(vx_ready), 1);
        check(vy_ready, "R6 vy_ready after reset", 32'(vy_ready), 1);

        // R1, R2, R7: table walk at the default width
        for (int i = 0; i < NT; i++) begin xs[i] = TX[i]; ys[i] = TY[i]; end
        base = got_n;
        push_pairs(NT);
        wait_results(base + NT);
        check(got_n == base + NT, "R2 result count", 32'(got_n - base), NT);
        for (int i = 0; i < NT; i++)
            check(got[base+i] == TE[i], "R1 table result", got[base+i], TE[i]);

        // R4: vx only, then vy
        base = got_n;
        for (int i = 0; i < 3; i++) begin
            xs[i] = 32'(100 + i); ys[i] = 32'(i * 3 + 1);
            push_x(xs[i]);
        end
        repeat (60) @(posedge clk);
        @(negedge clk);
        check(!norm_valid && got_n == base, "R4 no result without vy",
              32'(got_n - base), 0);
        for (int i = 0; i < 3; i++) push_y(ys[i]);
        wait_results(base + 3);
        for (int i = 0; i < 3; i++)
            check(got[base+i] == expect_norm(xs[i], ys[i]), "R4 late vy result",
                  got[base+i], expect_norm(xs[i], ys[i]));

        // R3: output back-pressure
        @(posedge clk); #2; norm_ready = 0;
        base = got_n;
        for (int i = 0; i < 5; i++) begin
            xs[i] = 32'hFFFF0000 + 32'(i); ys[i] = 32'(i + 9);
        end
        push_pairs(5);
        repeat (60) @(posedge clk);
        @(negedge clk);
        held = norm_data;
        check(norm_valid && held == expect_norm(xs[0], ys[0]), "R3 first held result",
              held, expect_norm(xs[0], ys[0]));
        repeat (5) @(negedge clk);
        check(norm_valid && norm_data == held, "R3 held stable", norm_data, held);
        @(posedge clk); #2; norm_ready = 1;
        wait_results(base + 5);
        check(got_n == base + 5, "R3 count after stall", 32'(got_n - base), 5);
        for (int i = 0; i < 5; i++)
            check(got[base+i] == expect_norm(xs[i], ys[i]), "R3 order after stall",
                  got[base+i], expect_norm(xs[i], ys[i]));

        // R5: fill vx path until ready drops
        base = got_n; acc = 0; stalled = 0;
        for (int i = 0; i < 400 && !stalled; i++) begin
            xs[i] = 32'(i * 7 + 2);
            @(posedge clk); #2;
            vx_valid = 1; vx_data = xs[i]; ok = 0;
            for (int c = 0; c < 30; c++) begin
                @(negedge clk);
                if (vx_ready) begin ok = 1; break; end
            end
            @(posedge clk); #2; vx_valid = 0;
            if (ok) acc++; else stalled = 1;
        end
        check(stalled, "R5 vx_ready drops when full", 32'(acc), 0);
        for (int i = 0; i < acc; i++) ys[i] = 32'(i + 1);
        for (int i = 0; i < acc; i++) push_y(ys[i]);
        wait_results(base + acc);
        check(got_n == base + acc, "R5 accepted count", 32'(got_n - base), 32'(acc));
        ok = 1;
        for (int i = 0; i < acc; i++)
            if (got[base+i] != expect_norm(xs[i], ys[i])) ok = 0;
        check(ok, "R5 all accepted words correct", 32'(ok), 1);

        // R6: reset mid-pair discards half-pairs
        push_x(32'd50); push_x(32'd60);
        repeat (20) @(posedge clk);
        do_reset();
        base = got_n;
        push_y(32'd1);
        repeat (60) @(posedge clk);
        @(negedge clk);
        check(!norm_valid && got_n == base, "R6 no stale result", 32'(got_n - base), 0);
        push_x(32'd2);
        wait_results(base + 1);
        check(got_n == base + 1 && got[base] == 32'd5, "R6 fresh pair after reset",
              got[base], 32'd5);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                total_n++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", pass_n, total_n);
        $finish;
    end
endmodule